// File: doc/BRIEF.md
# Signed 32/16 Divider with Status

This block divides a 32-bit two's complement dividend by a 16-bit two's complement divisor. The dividend arrives as two half-words, an upper and a lower one. The block returns a 16-bit quotient, a 16-bit remainder, a fixed-point overflow flag and a 4-bit condition status code. The quotient truncates toward zero, so a non-zero remainder always carries the sign of the dividend.

A caller pulses `start` while `busy` is low. The block takes the operand magnitudes into an unsigned shift-subtract core, which resolves one quotient bit per clock. Once the last bit is resolved, it corrects the signs and registers the results, then pulses `done` for one cycle. A zero divisor skips the iterations and reports overflow at once. The results hold until the next accepted start. An external interrupt or writeback stage reads them on `done`.

Top module: `sgn_div_wide`

## Requirements
- R1: The quotient is the signed dividend `{dividend_hi, dividend_lo}` divided by the signed `divisor`, truncated toward zero. The `quotient` port carries the low 16 bits of the full quotient in two's complement, even when overflow is flagged.
- R2: The `remainder` equals dividend minus quotient times divisor. Its magnitude is below that of the divisor. When non-zero, its sign bit (bit 15) equals the dividend's sign bit (bit 15 of `dividend_hi`).
- R3: `overflow` is 1 when the full quotient is above +32767 or below -32768, for example 0x00010000/1 or 0x80000000/-1. Otherwise it is 0 for a non-zero divisor.
- R4: A zero divisor gives `overflow`=1, `quotient`=0, `remainder`=0 and `status`=4'b0010. `done` is high in the cycle right after the accepting edge, and `busy` never rises.
- R5: `status` is 4'b0010 when `quotient` is zero and 4'b0001 when bit 15 of `quotient` is set. Otherwise it is 4'b0100.
- R6: A start is accepted on a clock edge where `start`=1 and `busy`=0. For a non-zero divisor, `busy` is high from that edge until `done` rises. `done` rises on the 33rd edge after the accepting edge and stays high for exactly one cycle.
- R7: `start` is ignored while `busy` is high. The result reflects the operands captured at the accepting edge.
- R8: While no start is accepted, `quotient`, `remainder`, `overflow` and `status` hold their values, and `done` stays low.
- R9: After reset, `busy`, `done`, `overflow`, `quotient` and `remainder` are 0 and `status` is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division with the present operands |
| dividend_hi | input | 16 | Most significant half of the dividend |
| dividend_lo | input | 16 | Least significant half of the dividend |
| divisor | input | 16 | Signed divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| quotient | output | 16 | Low half of the signed quotient |
| remainder | output | 16 | Signed remainder, same sign as the dividend |
| overflow | output | 1 | Zero divisor or quotient outside 16-bit signed range |
| status | output | 4 | Condition code of the quotient |

## Verification
The bench runs all four sign combinations and checks where truncation lands. A design that floors would return -15 instead of -14 for -100/7 and give the remainder the divisor's sign. It probes the edges of the overflow range (+32767, -32768, -32769, 65536) and the most negative dividend over -1 and over -32768. An off-by-one limit or a lossy absolute value of 0x80000000 would clear the flag or corrupt the low quotient bits there. It also starts a division with a zero divisor, pulses start during a run, and changes the inputs after completion. A design that iterates on zero, re-triggers while busy, or lets results drift while idle returns the wrong values or a stray `done` in those cases.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } sdiv_state_e;

   localparam logic [3:0] CS_NONE = 4'b0000;
   localparam logic [3:0] CS_NEG  = 4'b0001;
   localparam logic [3:0] CS_ZERO = 4'b0010;
   localparam logic [3:0] CS_POS  = 4'b0100;

   function automatic logic [3:0] cs_of(input logic is_neg, input logic is_zero);
      if (is_zero)     return CS_ZERO;
      else if (is_neg) return CS_NEG;
      else             return CS_POS;
   endfunction

endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
   parameter int DW = 16
) (
   input  logic [DW-1:0]   dvd_hi,
   input  logic [DW-1:0]   dvd_lo,
   input  logic [DW-1:0]   dvs,
   output logic [2*DW-1:0] dvd_mag,
   output logic [DW-1:0]   dvs_mag,
   output logic            dvd_neg,
   output logic            q_neg,
   output logic            dvs_zero
);
   localparam int WW = 2 * DW;

   logic [WW-1:0] dvd_full;

   always_comb begin
      dvd_full = {dvd_hi, dvd_lo};
      dvd_neg  = dvd_hi[DW-1];
      q_neg    = dvd_hi[DW-1] ^ dvs[DW-1];
      dvs_zero = (dvs == '0);
      // unsigned magnitudes: the most negative value maps onto its own bit pattern
      dvd_mag  = dvd_neg ? (~dvd_full + WW'(1)) : dvd_full;
      dvs_mag  = dvs[DW-1] ? (~dvs + DW'(1)) : dvs;
   end

endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
   parameter int DW           = 16,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   input  logic [2*DW-1:0] dvd_mag,
   input  logic [DW-1:0]   dvs_mag,
   output logic [2*DW-1:0] q_mag,
   output logic [DW-1:0]   r_mag
);
   localparam int WW = 2 * DW;
   localparam int PW = DW + 2;

   logic [WW-1:0] q_sh;
   logic [DW-1:0] dvs_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvs_r <= '0;
      end else if (load) begin
         dvs_r <= dvs_mag;
      end
   end

   assign q_mag = q_sh;

   generate
      if (NONRESTORING) begin : g_nonrestoring
         logic [PW-1:0] prem;
         logic [PW-1:0] shifted;
         logic [PW-1:0] nxt;
         logic [PW-1:0] dvs_ext;

         always_comb begin
            dvs_ext = {2'b00, dvs_r};
            shifted = {prem[DW:0], q_sh[WW-1]};
            nxt     = prem[PW-1] ? (shifted + dvs_ext) : (shifted - dvs_ext);
            r_mag   = prem[PW-1] ? (prem[DW-1:0] + dvs_r) : prem[DW-1:0];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prem <= '0;
               q_sh <= '0;
            end else if (load) begin
               prem <= '0;
               q_sh <= dvd_mag;
            end else if (step) begin
               prem <= nxt;
               q_sh <= {q_sh[WW-2:0], ~nxt[PW-1]};
            end
         end
      end else begin : g_restoring
         logic [DW-1:0] prem;
         logic [DW:0]   trial;
         logic          fits;

         always_comb begin
            trial = {prem, q_sh[WW-1]};
            fits  = (trial >= {1'b0, dvs_r});
            r_mag = prem;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prem <= '0;
               q_sh <= '0;
            end else if (load) begin
               prem <= '0;
               q_sh <= dvd_mag;
            end else if (step) begin
               prem <= fits ? (trial[DW-1:0] - dvs_r) : trial[DW-1:0];
               q_sh <= {q_sh[WW-2:0], fits};
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix #(
   parameter int DW = 16
) (
   input  logic [2*DW-1:0] q_mag,
   input  logic [DW-1:0]   r_mag,
   input  logic            q_neg,
   input  logic            dvd_neg,
   output logic [DW-1:0]   quo,
   output logic [DW-1:0]   rem,
   output logic            ovf,
   output logic [3:0]      status
);
   import sdiv_pkg::*;

   localparam int WW = 2 * DW;

   logic [WW-1:0] limit;

   always_comb begin
      // largest magnitude allowed: 2^(DW-1) for a negative quotient, one less otherwise
      limit  = {{DW{1'b0}}, q_neg, {(DW-1){~q_neg}}};
      ovf    = (q_mag > limit);
      quo    = q_neg ? (~q_mag[DW-1:0] + DW'(1)) : q_mag[DW-1:0];
      rem    = dvd_neg ? (~r_mag + DW'(1)) : r_mag;
      status = cs_of(quo[DW-1], quo == '0);
   end

endmodule

// File: rtl/sgn_div_wide.sv
module sgn_div_wide #(
   parameter int DW           = 16,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] dividend_hi,
   input  logic [DW-1:0] dividend_lo,
   input  logic [DW-1:0] divisor,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] quotient,
   output logic [DW-1:0] remainder,
   output logic          overflow,
   output logic [3:0]    status
);
   import sdiv_pkg::*;

   localparam int            WW   = 2 * DW;
   localparam int            CW   = $clog2(WW);
   localparam logic [CW-1:0] LAST = CW'(WW - 1);

   if (DW < 4) begin : g_bad_dw
      $error("sgn_div_wide: DW must be at least 4");
   end

   sdiv_state_e   state;
   logic [CW-1:0] cnt;
   logic          q_neg_r, dvd_neg_r;

   logic [WW-1:0] dvd_mag, q_mag;
   logic [DW-1:0] dvs_mag, r_mag;
   logic          dvd_neg, q_neg, dvs_zero;
   logic [DW-1:0] fx_quo, fx_rem;
   logic          fx_ovf;
   logic [3:0]    fx_status;
   logic          accept, core_load, core_step;

   sdiv_prep #(.DW(DW)) u_prep (
      .dvd_hi   (dividend_hi),
      .dvd_lo   (dividend_lo),
      .dvs      (divisor),
      .dvd_mag  (dvd_mag),
      .dvs_mag  (dvs_mag),
      .dvd_neg  (dvd_neg),
      .q_neg    (q_neg),
      .dvs_zero (dvs_zero)
   );

   sdiv_core #(.DW(DW), .NONRESTORING(NONRESTORING)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (core_load),
      .step    (core_step),
      .dvd_mag (dvd_mag),
      .dvs_mag (dvs_mag),
      .q_mag   (q_mag),
      .r_mag   (r_mag)
   );

   sdiv_fix #(.DW(DW)) u_fix (
      .q_mag   (q_mag),
      .r_mag   (r_mag),
      .q_neg   (q_neg_r),
      .dvd_neg (dvd_neg_r),
      .quo     (fx_quo),
      .rem     (fx_rem),
      .ovf     (fx_ovf),
      .status  (fx_status)
   );

   assign busy      = (state != ST_IDLE);
   assign accept    = start && (state == ST_IDLE);
   assign core_load = accept && !dvs_zero;
   assign core_step = (state == ST_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         q_neg_r   <= 1'b0;
         dvd_neg_r <= 1'b0;
         done      <= 1'b0;
         quotient  <= '0;
         remainder <= '0;
         overflow  <= 1'b0;
         status    <= CS_NONE;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (dvs_zero) begin
                     quotient  <= '0;
                     remainder <= '0;
                     overflow  <= 1'b1;
                     status    <= CS_ZERO;
                     done      <= 1'b1;
                  end else begin
                     q_neg_r   <= q_neg;
                     dvd_neg_r <= dvd_neg;
                     cnt       <= '0;
                     state     <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               cnt <= cnt + CW'(1);
               if (cnt == LAST) state <= ST_FIN;
            end
            ST_FIN: begin
               quotient  <= fx_quo;
               remainder <= fx_rem;
               overflow  <= fx_ovf;
               status    <= fx_status;
               done      <= 1'b1;
               state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

module sdiv_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          dvd_sign,
   input logic [DW-1:0] divisor,
   input logic          busy,
   input logic          done,
   input logic [DW-1:0] quotient,
   input logic [DW-1:0] remainder,
   input logic          overflow,
   input logic [3:0]    status
);
   logic cap_sign;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cap_sign <= 1'b0;
      else if (start && !busy)  cap_sign <= dvd_sign;
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                    // R6
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                                    // R6
   AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);                                              // R6
   AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && divisor == '0) |=>
         (done && overflow && !busy && quotient == '0 && remainder == '0 && status == 4'b0010)); // R4
   AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status == ((quotient == '0) ? 4'b0010 :
                           (quotient[DW-1] ? 4'b0001 : 4'b0100))));      // R5
   AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && remainder != '0) |-> (remainder[DW-1] == cap_sign));       // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(quotient) && $stable(remainder) &&
                             $stable(overflow) && $stable(status) && !done)); // R8
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy || done));                                // R7

endmodule

bind sgn_div_wide sdiv_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .dvd_sign  (dividend_hi[DW-1]),
   .divisor   (divisor),
   .busy      (busy),
   .done      (done),
   .quotient  (quotient),
   .remainder (remainder),
   .overflow  (overflow),
   .status    (status)
);

// File: tb/tb_sgn_div_wide.sv
`timescale 1ns/1ps
module tb_sgn_div_wide;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [DW-1:0] dividend_hi = '0;
   logic [DW-1:0] dividend_lo = '0;
   logic [DW-1:0] divisor = '0;
   logic          busy, done, overflow;
   logic [DW-1:0] quotient, remainder;
   logic [3:0]    status;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   sgn_div_wide #(.DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .dividend_hi(dividend_hi), .dividend_lo(dividend_lo), .divisor(divisor),
      .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
      .overflow(overflow), .status(status)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // reference model built from the requirements
   task automatic model(input logic [31:0] dvd, input logic [15:0] dv,
                        output logic [15:0] eq, output logic [15:0] er,
                        output logic eo, output logic [3:0] es);
      longint a, b, q, r;
      logic [63:0] qq, rr;
      a = longint'($signed(dvd));
      b = longint'($signed(dv));
      if (b == 0) begin
         eq = '0; er = '0; eo = 1'b1;
      end else begin
         q = a / b;
         r = a % b;
         qq = q; rr = r;
         eq = qq[15:0]; er = rr[15:0];
         eo = (q > 32767) || (q < -32768);
      end
      es = (eq == 0) ? 4'b0010 : (eq[15] ? 4'b0001 : 4'b0100);
   endtask

   // issue one division; optionally pulse start again mid-run with other operands (R7)
   task automatic run_div(input logic [31:0] dvd, input logic [15:0] dv, input bit poke);
      logic [15:0] eq, er;
      logic eo;
      logic [3:0] es;
      int n;
      int exp_n;
      model(dvd, dv, eq, er, eo, es);
      @(negedge clk);
      {dividend_hi, dividend_lo} = dvd;
      divisor = dv;
      start = 1'b1;
      n = 0;
      forever begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            start = 1'b0;
            dividend_hi = 16'hA5A5; dividend_lo = 16'h5A5A; divisor = 16'h0003;
         end
         if (poke && n == 5) start = 1'b1;
         if (poke && n == 6) start = 1'b0;
         if (done || n > 100) break;
      end
      // accepting edge is followed by negedge 1; done rises on edge 33 after it
      exp_n = (dv == 0) ? 1 : 2*DW + 2;
      chk(dv == 0 ? "R4" : "R6", "done latency", n, exp_n);
      chk(poke ? "R7" : "R1", "quotient", quotient, eq);
      chk("R2", "remainder", remainder, er);
      chk(dv == 0 ? "R4" : "R3", "overflow", overflow, eo);
      chk("R5", "status", status, es);
      @(negedge clk);
      chk("R6", "done one cycle", done, 0);
   endtask

   task automatic t_reset;
      chk("R9", "busy", busy, 0);
      chk("R9", "done", done, 0);
      chk("R9", "quotient", quotient, 0);
      chk("R9", "remainder", remainder, 0);
      chk("R9", "overflow", overflow, 0);
      chk("R9", "status", status, 0);
   endtask

   task automatic t_signs;
      run_div(32'd100, 16'd7, 0);
      run_div(-32'sd100, 16'd7, 0);
      run_div(32'd100, -16'sd7, 0);
      run_div(-32'sd100, -16'sd7, 0);
      run_div(-32'sd7, 16'd100, 0);
      run_div(32'd7, 16'h8000, 0);
      run_div(32'd0, 16'd5, 0);
      run_div(32'h1234_5678, 16'h7FFF, 0);
   endtask

   task automatic t_overflow;
      run_div(32'd65535, 16'd2, 0);
      run_div(-32'sd65536, 16'd2, 0);
      run_div(-32'sd65538, 16'd2, 0);
      run_div(32'h0001_0000, 16'd1, 0);
      run_div(32'h8000_0000, 16'hFFFF, 0);
      run_div(32'h8000_0000, 16'h8000, 0);
      run_div(32'h8000_0000, 16'd7, 0);
   endtask

   task automatic t_div_zero;
      run_div(32'h0000_1234, 16'd0, 0);
      run_div(32'hFFFF_FF00, 16'd0, 0);
   endtask

   task automatic t_start_ignored;
      run_div(32'd1000, -16'sd3, 1);
   endtask

   task automatic t_hold;
      logic [15:0] q0, r0;
      logic o0;
      logic [3:0] s0;
      bit saw_done;
      run_div(-32'sd12345, 16'd10, 0);
      q0 = quotient; r0 = remainder; o0 = overflow; s0 = status;
      saw_done = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         dividend_hi = 16'(i * 77); dividend_lo = 16'(i * 911); divisor = 16'(i);
         if (done) saw_done = 1'b1;
      end
      chk("R8", "held quotient", quotient, q0);
      chk("R8", "held remainder", remainder, r0);
      chk("R8", "held overflow", overflow, o0);
      chk("R8", "held status", status, s0);
      chk("R8", "no stray done", saw_done, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_signs();
      t_overflow();
      t_div_zero();
      t_start_ignored();
      t_hold();
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule